// File: doc/BRIEF.md
# Prioritized UART Interrupt Identification

This block merges the interrupt sources of a UART into a single interrupt line and an 8-bit identification value that the host reads. The sources fall into four priority classes. From highest to lowest they are receiver line status, receive data available or character time-out, transmit holding register empty, and modem status. Each class has its own enable bit. The identification value reports only the highest-priority class that is pending and enabled.

Line status, receive data, time-out and modem status arrive as level conditions. The surrounding UART holds each one until the host services its cause. The holding-register-empty source arrives as a one-cycle pulse and is latched inside the block. That latch clears in two ways: a host read of the identification value while that class is the one being reported, or a host write to the holding register. Both outputs are registered, so they follow the inputs by one clock cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: During and after reset, with no source pending, `ident` reads 8'h01 and `irq` is 0.
- R2: When several enabled classes are pending, the one reported is, from highest to lowest: line status, receive data or time-out, holding register empty, modem status.
- R3: `ident[0]` is 0 exactly when an enabled class is pending, and `irq` is the inverse of `ident[0]`. With nothing pending, `ident[3:0]` is 4'b0001.
- R4: The codes in `ident[3:0]` are: line status 4'b0110, receive data 4'b0100, holding register empty 4'b0010, modem status 4'b0000.
- R5: In FIFO mode, a pending time-out is reported as 4'b1100. This means `ident[3]` is set together with `ident[2]`, and the time-out code takes precedence over the plain receive-data code. Outside FIFO mode, `rx_timeout` has no effect and `ident[3]` stays 0.
- R6: `ident[5:4]` is always 0. `ident[7:6]` is 2'b11 in FIFO mode and 2'b00 outside it.
- R7: Enable bit positions are: `ier[0]` receive data/time-out, `ier[1]` holding register empty, `ier[2]` line status, `ier[3]` modem status. A class whose enable bit is clear is never reported. With `ier` all zero, `irq` stays 0.
- R8: A pulse on `thr_empty_evt` latches a holding-register-empty pending state. The state clears on `thr_write`, or on `ident_rd` while `ident[3:0]` shows 4'b0010. A new pulse in the same cycle as a clear wins.
- R9: An `ident_rd` while a class other than holding register empty is reported does not clear a latched holding-register-empty state.
- R10: `ident` and `irq` are registered. They reflect the sources, enables and mode sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_status | input | 1 | Receiver line status condition pending (level) |
| rx_ready | input | 1 | Received data available (level) |
| rx_timeout | input | 1 | Character time-out pending (level, used in FIFO mode only) |
| thr_empty_evt | input | 1 | One-cycle pulse when the holding register becomes empty |
| modem_status | input | 1 | Modem status change pending (level) |
| ier | input | 4 | Per-class interrupt enables |
| fifo_mode | input | 1 | FIFO mode enabled |
| ident_rd | input | 1 | Host read strobe of the identification value |
| thr_write | input | 1 | Host write strobe of the holding register |
| irq | output | 1 | Interrupt request, active high |
| ident | output | 8 | Interrupt identification value |

## Verification
On every cycle, the assertions check these fixed-format properties:
- `irq` and `ident[0]` always agree.
- The reserved bits stay zero.
- The FIFO indicator bits track the mode.
- The time-out flag appears only in FIFO mode.
- A pending line-status source always wins.
- A zero enable register keeps `irq` low.
- The holding-register-empty latch sets and clears on its strobes.

Other behaviours can only be shown by the bench's scenarios against its cycle-level reference model:
- the full priority order as higher classes drop away;
- a read clearing the holding-register-empty class only when that class is reported;
- `rx_timeout` being ignored outside FIFO mode.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_CLASS = 4;
  localparam int IDENT_W   = 8;

  // Enable bit positions inside ier
  localparam int EN_RXDATA = 0;
  localparam int EN_THRE   = 1;
  localparam int EN_LINE   = 2;
  localparam int EN_MODEM  = 3;

  typedef enum logic [3:0] {
    ID_LINE    = 4'b0110,
    ID_RXDATA  = 4'b0100,
    ID_TIMEOUT = 4'b1100,
    ID_THRE    = 4'b0010,
    ID_MODEM   = 4'b0000,
    ID_NONE    = 4'b0001
  } iid_code_e;

  // Priority rank (0 = highest) to enable bit position
  function automatic int rank_enable_bit(int rank);
    case (rank)
      0:       return EN_LINE;
      1:       return EN_RXDATA;
      2:       return EN_THRE;
      default: return EN_MODEM;
    endcase
  endfunction

  // Priority rank to reported code
  function automatic iid_code_e rank_code(int rank, logic tmo);
    case (rank)
      0:       return ID_LINE;
      1:       return tmo ? ID_TIMEOUT : ID_RXDATA;
      2:       return ID_THRE;
      default: return ID_MODEM;
    endcase
  endfunction

  // Assemble the full identification byte
  function automatic logic [IDENT_W-1:0] pack_ident(iid_code_e code, logic fifo);
    return {{2{fifo}}, 2'b00, code};
  endfunction

endpackage

// File: rtl/uart_irq_thre_latch.sv
module uart_irq_thre_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_clr,
  input  logic rd_clr,
  output logic pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend <= 1'b0;
    else if (set_evt)          pend <= 1'b1;
    else if (wr_clr || rd_clr) pend <= 1'b0;
  end

  AST_THRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend); // R8
  AST_THRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && (wr_clr || rd_clr)) |=> !pend); // R8

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NUM_CLASS
) (
  input  logic [N-1:0] active,
  input  logic         tmo_sel,
  output iid_code_e    code
);

  // Walk from lowest to highest priority so the highest one wins
  always_comb begin
    code = ID_NONE;
    for (int r = N - 1; r >= 0; r--) begin
      if (active[r]) code = rank_code(r, tmo_sel);
    end
  end

endmodule

// File: rtl/uart_irq_out_reg.sv
module uart_irq_out_reg
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  iid_code_e          code,
  input  logic               fifo_mode,
  output logic [IDENT_W-1:0] ident_q,
  output logic               irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q <= pack_ident(ID_NONE, 1'b0);
      irq_q   <= 1'b0;
    end else begin
      ident_q <= pack_ident(code, fifo_mode);
      irq_q   <= (code != ID_NONE);
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_status,
  input  logic                 rx_ready,
  input  logic                 rx_timeout,
  input  logic                 thr_empty_evt,
  input  logic                 modem_status,
  input  logic [NUM_CLASS-1:0] ier,
  input  logic                 fifo_mode,
  input  logic                 ident_rd,
  input  logic                 thr_write,
  output logic                 irq,
  output logic [IDENT_W-1:0]   ident
);

  logic                 thre_pend;
  logic                 tmo_sel;
  logic                 thre_reported;
  logic [NUM_CLASS-1:0] raw_by_rank;
  logic [NUM_CLASS-1:0] active_by_rank;
  iid_code_e            next_code;

  // Time-out counts only in FIFO mode
  assign tmo_sel       = fifo_mode && rx_timeout;
  assign thre_reported = (ident[3:0] == ID_THRE);

  assign raw_by_rank[0] = line_status;
  assign raw_by_rank[1] = rx_ready || tmo_sel;
  assign raw_by_rank[2] = thre_pend;
  assign raw_by_rank[3] = modem_status;

  for (genvar r = 0; r < NUM_CLASS; r++) begin : g_gate
    assign active_by_rank[r] = raw_by_rank[r] && ier[rank_enable_bit(r)];
  end

  uart_irq_thre_latch u_thre (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (thr_empty_evt),
    .wr_clr  (thr_write),
    .rd_clr  (ident_rd && thre_reported),
    .pend    (thre_pend)
  );

  uart_irq_prio_enc #(.N(NUM_CLASS)) u_enc (
    .active  (active_by_rank),
    .tmo_sel (tmo_sel),
    .code    (next_code)
  );

  uart_irq_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (next_code),
    .fifo_mode (fifo_mode),
    .ident_q   (ident),
    .irq_q     (irq)
  );

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !ident[0]); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ident[5:4] == 2'b00); // R6
  AST_FIFO_FLAGS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_mode |=> ident[7:6] == 2'b11); // R6
  AST_FIFO_FLAGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> ident[7:6] == 2'b00); // R6
  AST_TMO_FIFO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ident[3] |-> (ident[7:6] == 2'b11 && ident[2])); // R5
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (line_status && ier[EN_LINE]) |=> ident[3:0] == ID_LINE); // R2
  AST_IER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == '0) |=> !irq); // R7

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_status = 0, rx_ready = 0, rx_timeout = 0, thr_empty_evt = 0;
  logic       modem_status = 0, fifo_mode = 0, ident_rd = 0, thr_write = 0;
  logic [3:0] ier = 4'h0;
  logic       irq;
  logic [7:0] ident;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Reference model state
  bit       m_thre = 0;
  bit [7:0] m_ident = 8'h01;
  bit       m_irq = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .line_status(line_status), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .thr_empty_evt(thr_empty_evt),
    .modem_status(modem_status), .ier(ier), .fifo_mode(fifo_mode),
    .ident_rd(ident_rd), .thr_write(thr_write), .irq(irq), .ident(ident)
  );

  // Behavioural model, written as a plain decision chain
  always @(posedge clk or negedge rst_n) begin
    bit [7:0] nxt;
    if (!rst_n) begin
      m_thre = 0; m_ident = 8'h01; m_irq = 0;
    end else begin
      nxt = 8'h01;
      if (ier[2] && line_status)                                nxt = 8'h06;
      else if (ier[0] && fifo_mode && rx_timeout)               nxt = 8'h0C;
      else if (ier[0] && rx_ready)                              nxt = 8'h04;
      else if (ier[1] && m_thre)                                nxt = 8'h02;
      else if (ier[3] && modem_status)                          nxt = 8'h00;
      if (fifo_mode) nxt = nxt + 8'hC0;
      if (thr_empty_evt) m_thre = 1;
      else if (thr_write || (ident_rd && m_ident[3:0] == 4'h2)) m_thre = 0;
      m_ident = nxt;
      m_irq   = (nxt[0] == 1'b0);
    end
  end

  task automatic compare_model();
    checks++;
    if (ident !== m_ident || irq !== m_irq) begin
      errors++;
      $display("FAIL %s: ident=%h exp=%h irq=%b exp=%b", cur_req, ident, m_ident, irq, m_irq);
    end
  endtask

  task automatic check_lit(string req, logic [7:0] exp_id, logic exp_irq);
    checks++;
    if (ident !== exp_id || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s: ident=%h exp=%h irq=%b exp=%b", req, ident, exp_id, irq, exp_irq);
    end
  endtask

  // Advance one cycle, sample 2 ns after the edge, compare with model
  task automatic cyc();
    @(posedge clk); #2;
    compare_model();
  endtask

  task automatic pulse_thre();
    thr_empty_evt = 1; cyc(); thr_empty_evt = 0;
  endtask

  task automatic host_read();
    ident_rd = 1; cyc(); ident_rd = 0;
  endtask

  task automatic clear_all();
    line_status = 0; rx_ready = 0; rx_timeout = 0; modem_status = 0;
    thr_write = 1; cyc(); thr_write = 0; cyc();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check_lit("R1", 8'h01, 1'b0);            // R1 in reset
    rst_n = 1;
    cyc(); check_lit("R1", 8'h01, 1'b0);     // R1 after reset

    // R7: everything pending, nothing enabled
    cur_req = "R7";
    line_status = 1; rx_ready = 1; modem_status = 1; pulse_thre();
    repeat (3) cyc();
    check_lit("R7", 8'h01, 1'b0);
    ier = 4'b1011; cyc(); cyc();            // line status disabled -> rx data
    check_lit("R7", 8'h04, 1'b1);
    clear_all();

    // R4: each class alone
    cur_req = "R4"; ier = 4'hF;
    line_status = 1; cyc(); check_lit("R4", 8'h06, 1'b1); line_status = 0; cyc();
    rx_ready = 1; cyc(); check_lit("R4", 8'h04, 1'b1); rx_ready = 0; cyc();
    modem_status = 1; cyc(); check_lit("R4", 8'h00, 1'b1); modem_status = 0; cyc();
    cur_req = "R10";
    check_lit("R10", 8'h01, 1'b0);
    pulse_thre(); cyc(); check_lit("R4", 8'h02, 1'b1);
    thr_write = 1; cyc(); thr_write = 0; cyc();
    cur_req = "R8"; check_lit("R8", 8'h01, 1'b0); // write clears

    // R2: all at once, remove from the top down
    cur_req = "R2";
    line_status = 1; rx_ready = 1; modem_status = 1; pulse_thre(); cyc();
    check_lit("R2", 8'h06, 1'b1);
    line_status = 0; cyc(); cyc(); check_lit("R2", 8'h04, 1'b1);
    rx_ready = 0; cyc(); cyc(); check_lit("R2", 8'h02, 1'b1);
    thr_write = 1; cyc(); thr_write = 0; cyc(); check_lit("R2", 8'h00, 1'b1);
    clear_all();

    // R5: time-out ignored outside FIFO mode, coded in FIFO mode
    cur_req = "R5";
    rx_timeout = 1; cyc(); cyc(); check_lit("R5", 8'h01, 1'b0);
    fifo_mode = 1; cyc(); check_lit("R5", 8'hCC, 1'b1);
    rx_ready = 1; cyc(); check_lit("R5", 8'hCC, 1'b1);
    rx_timeout = 0; cyc(); check_lit("R5", 8'hC4, 1'b1);
    rx_ready = 0;

    // R6: FIFO indicator bits
    cur_req = "R6";
    cyc(); check_lit("R6", 8'hC1, 1'b0);
    fifo_mode = 0; cyc(); check_lit("R6", 8'h01, 1'b0);

    // R8: read while holding-register-empty reported clears it
    cur_req = "R8";
    pulse_thre(); cyc(); check_lit("R8", 8'h02, 1'b1);
    host_read(); cyc(); check_lit("R8", 8'h01, 1'b0);
    // new pulse in the same cycle as a read-clear: set wins
    pulse_thre(); cyc();
    thr_empty_evt = 1; ident_rd = 1; cyc(); thr_empty_evt = 0; ident_rd = 0;
    cyc(); cyc(); check_lit("R8", 8'h02, 1'b1);
    clear_all();

    // R9: read while line status reported leaves the latch alone
    cur_req = "R9";
    line_status = 1; pulse_thre(); cyc(); check_lit("R9", 8'h06, 1'b1);
    host_read(); host_read();
    line_status = 0; cyc(); cyc(); check_lit("R9", 8'h02, 1'b1);
    clear_all();

    // R3 and R10 across a mixed random-ish pattern
    cur_req = "R3";
    for (int i = 0; i < 200; i++) begin
      line_status  = (i % 7) == 3;
      rx_ready     = (i % 5) == 1;
      rx_timeout   = (i % 11) < 3;
      modem_status = (i % 3) == 0;
      fifo_mode    = (i % 17) > 8;
      ier          = 4'(i * 7 + 3);
      thr_empty_evt = (i % 9) == 2;
      ident_rd     = (i % 4) == 0;
      thr_write    = (i % 13) == 6;
      cyc();
    end
    thr_empty_evt = 0; ident_rd = 0; thr_write = 0;
    cyc();

    done = 1;
    finish_run();
  end

endmodule